// File: doc/BRIEF.md
# Start-up Bad Block Scanner

This controller runs once after reset and builds a table of the NAND blocks that must not be used. It works through a simple read port. For every block in turn, it fetches the first spare byte of the first two pages of the block. A host NAND controller serves each request and returns one byte. The scanner treats a block as unusable when either fetched marker byte differs from FFh. Factory-marked blocks normally carry 00h in that byte, but any other non-FFh value also counts as bad.

Block 0 is guaranteed to be good. The scanner never reads it and never marks it bad. When the second-to-last block has been visited and the last block is finished, the scanner raises its done flag and stops requesting. It then exposes four results:

- a one-bit-per-block bad map;
- the number of bad blocks;
- an error flag, set when more blocks are bad than the guaranteed minimum of good blocks allows;
- a lookup port that answers whether a chosen block may be used.

The read port can only fetch data, so the scanner cannot start a program or erase operation. Such an operation would destroy the markers.

Top module: `bbs_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `scanDone`, `lkReady`, `lkUsable`, `badCount` and `tooManyBad` are all 0.
- R2: Reads are requested in ascending block order, from block 1 to block NUM_BLOCKS-1. Within a block, page 0 is read before page 1. Each read uses `rdRow` = block*16 + page, with the block in `rdRow[11:4]` and the page in `rdRow[3:0]`, and `rdCol` = 256. The request and row stay unchanged until `rdAck` is seen.
- R3: No read is ever issued for block 0. Block 0 is never reported bad.
- R4: A block whose page-0 marker is not FFh is marked bad. This holds for 00h and for other values such as FEh.
- R5: When the page-0 marker of a block is bad, page 1 of that block is not read, and the next read goes to page 0 of the following block.
- R6: A block with a good page-0 marker and a non-FFh page-1 marker is marked bad.
- R7: `badCount` equals the number of set bits in `badMap`, where bit b stands for block b.
- R8: `tooManyBad` is 1 exactly when `badCount` is greater than 5, and 0 when it is 5 or less.
- R9: After the acknowledge of the last read of the last block, `scanDone` rises and stays at 1, and `rdReq` stays at 0.
- R10: `lkReady` equals `scanDone`. `lkUsable` is 1 only when the scan is done and block `lkBlock` is not marked bad. Before the scan completes, `lkUsable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the scan starts when it is released |
| rdReq | output | 1 | Read request to the host NAND controller |
| rdRow | output | 12 | Row (page) address of the request |
| rdCol | output | 9 | Column of the marker byte (constant 256) |
| rdAck | input | 1 | One-cycle pulse: `rdData` holds the requested byte |
| rdData | input | 8 | Marker byte returned by the host controller |
| scanDone | output | 1 | Scan complete |
| badMap | output | 256 | Bit b set when block b is bad |
| badCount | output | 9 | Number of bad blocks |
| tooManyBad | output | 1 | More bad blocks than allowed |
| lkBlock | input | 8 | Block to look up |
| lkReady | output | 1 | Lookup answer is valid |
| lkUsable | output | 1 | Looked-up block is usable |

## Verification
Four marker patterns are applied, each with a different acknowledge latency:

- All blocks clean. This sets the baseline of two reads per block and zero bad blocks.
- A scattered mix. Some blocks fail on page 0, some only on page 1, some on both. The marker values include 00h, FEh and 7Fh. One of the failing blocks is the last block, and block 0's marker is bad. This pattern separates the page-0 skip from the page-1 check, and it exposes any wrong handling of block 0.
- Exactly five bad blocks and seven bad blocks. These two counts bracket the error-flag threshold.

After each scan, every block is looked up through the lookup port and compared with the bad map. The bench counts the reads it served and compares them with the count its own pattern predicts. It also checks the order of the row addresses it served.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  // Strobes from the control FSM to the datapath, at most one per cycle.
  typedef struct packed {
    logic markBad;    // current block failed; count it, move to the next block
    logic nextPage;   // marker good, read the next marker page
    logic nextBlock;  // block finished, move on
  } scanStrobe_t;

  typedef enum logic [0:0] {
    ST_SCAN = 1'b0,
    ST_DONE = 1'b1
  } scanState_t;
endpackage

// File: rtl/bbs_dp.sv
module bbs_dp
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 256,
  parameter int PAGES_PER_BLOCK = 16,
  parameter int MARKER_PAGES    = 2,
  parameter int MAX_BAD         = 5,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W = BLK_W + PG_W,
  localparam int CNT_W = BLK_W + 1,
  localparam int MP_W  = (MARKER_PAGES > 1) ? $clog2(MARKER_PAGES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  scanStrobe_t           strobe,
  input  logic                  rdReq,
  input  logic                  rdAck,
  input  logic [7:0]            rdData,
  input  logic [BLK_W-1:0]      lkBlock,
  output logic [ROW_W-1:0]      rdRow,
  output logic                  markerBad,
  output logic                  pageLast,
  output logic                  blockLast,
  output logic [NUM_BLOCKS-1:0] badMap,
  output logic [CNT_W-1:0]      badCount,
  output logic                  tooManyBad,
  output logic                  lkBad
);
  logic [BLK_W-1:0] curBlock;
  logic [MP_W-1:0]  curPage;
  logic [PG_W-1:0]  pageField;

  assign pageField  = PG_W'(curPage);
  assign rdRow      = {curBlock, pageField};
  assign markerBad  = (rdData != 8'hFF);
  assign pageLast   = (curPage == MP_W'(MARKER_PAGES - 1));
  assign blockLast  = (curBlock == BLK_W'(NUM_BLOCKS - 1));
  assign tooManyBad = (badCount > CNT_W'(MAX_BAD));
  assign lkBad      = badMap[lkBlock];

  // Block 0 is never requested: the walk starts at block 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      curBlock <= BLK_W'(1);
      curPage  <= '0;
    end else if (strobe.nextBlock || strobe.markBad) begin
      curPage <= '0;
      if (!blockLast) curBlock <= curBlock + BLK_W'(1);
    end else if (strobe.nextPage) begin
      curPage <= curPage + MP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      badMap   <= '0;
      badCount <= '0;
    end else if (strobe.markBad && curBlock != '0) begin
      badMap[curBlock] <= 1'b1;
      badCount         <= badCount + CNT_W'(1);
    end
  end

  // R2
  row_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdRow)));
  // R3
  no_block0_read_chk: assert property (@(posedge clk) disable iff (rst)
    rdReq |-> (rdRow[ROW_W-1:PG_W] != '0));
  // R5
  skip_second_page_chk: assert property (@(posedge clk) disable iff (rst)
    (rdReq && rdAck && markerBad) |=> (curPage == '0));
  // R7
  count_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    (badCount != $past(badCount)) |-> (badCount == $past(badCount) + CNT_W'(1)));
endmodule

// File: rtl/bbs_ctl.sv
module bbs_ctl
  import bbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rdAck,
  input  logic        markerBad,
  input  logic        pageLast,
  input  logic        blockLast,
  output scanStrobe_t strobe,
  output logic        rdReq,
  output logic        scanDone
);
  scanState_t state, stateNext;

  assign rdReq    = (state == ST_SCAN) && !rst;
  assign scanDone = (state == ST_DONE);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (state == ST_SCAN && rdAck) begin
      if (markerBad)     strobe.markBad   = 1'b1;
      else if (pageLast) strobe.nextBlock = 1'b1;
      else               strobe.nextPage  = 1'b1;
      if ((strobe.markBad || strobe.nextBlock) && blockLast) stateNext = ST_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SCAN;
    else     state <= stateNext;
  end

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    scanDone |=> (scanDone && !rdReq));
  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.markBad, strobe.nextPage, strobe.nextBlock}));
endmodule

// File: rtl/bbs_top.sv
module bbs_top
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 256,
  parameter int PAGES_PER_BLOCK = 16,
  parameter int MARKER_PAGES    = 2,
  parameter int COL_W           = 9,
  parameter int MARKER_COL      = 256,
  parameter int MAX_BAD         = 5,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W = BLK_W + PG_W,
  localparam int CNT_W = BLK_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic                  rdReq,
  output logic [ROW_W-1:0]      rdRow,
  output logic [COL_W-1:0]      rdCol,
  input  logic                  rdAck,
  input  logic [7:0]            rdData,
  output logic                  scanDone,
  output logic [NUM_BLOCKS-1:0] badMap,
  output logic [CNT_W-1:0]      badCount,
  output logic                  tooManyBad,
  input  logic [BLK_W-1:0]      lkBlock,
  output logic                  lkReady,
  output logic                  lkUsable
);
  scanStrobe_t strobe;
  logic markerBad, pageLast, blockLast, lkBad;

  assign rdCol    = COL_W'(MARKER_COL);
  assign lkReady  = scanDone;
  assign lkUsable = scanDone && !lkBad;

  bbs_ctl i_ctl (
    .clk(clk), .rst(rst), .rdAck(rdAck), .markerBad(markerBad),
    .pageLast(pageLast), .blockLast(blockLast), .strobe(strobe),
    .rdReq(rdReq), .scanDone(scanDone)
  );

  bbs_dp #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .MARKER_PAGES(MARKER_PAGES), .MAX_BAD(MAX_BAD)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdReq(rdReq), .rdAck(rdAck),
    .rdData(rdData), .lkBlock(lkBlock), .rdRow(rdRow), .markerBad(markerBad),
    .pageLast(pageLast), .blockLast(blockLast), .badMap(badMap),
    .badCount(badCount), .tooManyBad(tooManyBad), .lkBad(lkBad)
  );

  // R10
  lookup_gated_chk: assert property (@(posedge clk) disable iff (rst)
    lkUsable |-> lkReady);
endmodule

// File: tb/test_bbs_top.sv
module test_bbs_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdReq, rdAck, scanDone, tooManyBad, lkReady, lkUsable;
  logic [11:0] rdRow;
  logic [8:0]  rdCol, badCount;
  logic [7:0]  rdData, lkBlock;
  logic [255:0] badMap;

  int checks = 0, failures = 0, cycles = 0;
  int sc = 0, lat = 0, waitCnt = 0, readCnt = 0, orderErr = 0, colErr = 0;
  int expBlk = 1, expPg = 0;

  always #5 clk = ~clk;

  bbs_top i_bbs_top (
    .clk(clk), .rst(rst), .rdReq(rdReq), .rdRow(rdRow), .rdCol(rdCol),
    .rdAck(rdAck), .rdData(rdData), .scanDone(scanDone), .badMap(badMap),
    .badCount(badCount), .tooManyBad(tooManyBad), .lkBlock(lkBlock),
    .lkReady(lkReady), .lkUsable(lkUsable)
  );

  function automatic logic [7:0] marker(int s, int b, int p);
    case (s)
      1: begin
        if (b == 0)   return 8'h00;
        if (b == 3   && p == 0) return 8'h00;
        if (b == 7   && p == 1) return 8'h00;
        if (b == 100 && p == 0) return 8'hFE;
        if (b == 100 && p == 1) return 8'h00;
        if (b == 255 && p == 1) return 8'h7F;
        return 8'hFF;
      end
      2: begin
        if (b % 50 == 1 && p == 0) return 8'h00;
        if (b == 254 && p == 1)    return 8'h00;
        return 8'hFF;
      end
      3: begin
        if ((b == 10 || b == 20 || b == 30 || b == 40) && p == 1) return 8'h00;
        if (b == 255 && p == 0) return 8'h00;
        return 8'hFF;
      end
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit expBad(int s, int b);
    return b != 0 && (marker(s, b, 0) != 8'hFF || marker(s, b, 1) != 8'hFF);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Host read port model with a configurable acknowledge latency.
  initial begin
    rdAck = 1'b0; rdData = 8'h00;
    forever begin
      @(negedge clk);
      rdAck = 1'b0;
      if (!rst && rdReq) begin
        if (waitCnt >= lat) begin
          int b, p;
          waitCnt = 0;
          b = int'(rdRow[11:4]);
          p = int'(rdRow[3:0]);
          if (b != expBlk || p != expPg) orderErr++;
          if (rdCol != 9'd256) colErr++;
          rdData = marker(sc, b, p);
          rdAck = 1'b1;
          readCnt++;
          if (rdData != 8'hFF || p == 1) begin expBlk++; expPg = 0; end
          else expPg = 1;
        end else waitCnt++;
      end
    end
  end

  task automatic runScan(int s, int l);
    int expReads = 0, expCount = 0, mapErr = 0, lkErr = 0;
    sc = s; lat = l; waitCnt = 0; readCnt = 0; orderErr = 0; colErr = 0;
    expBlk = 1; expPg = 0;
    rst = 1'b1; lkBlock = 8'd5;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!scanDone && !lkReady && !lkUsable && badCount == 0 && !tooManyBad,
        "R1 reset outputs", int'(scanDone), 0);
    @(posedge clk); rst = 1'b0;
    @(negedge clk);
    // R1, R10 first cycle after reset
    chk(!scanDone && badCount == 0, "R1 after reset", int'(badCount), 0);
    chk(!lkReady && !lkUsable, "R10 lookup before done", int'(lkUsable), 0);
    while (!scanDone && cycles < 150000) @(negedge clk);
    for (int b = 0; b < 256; b++) begin
      if (b != 0) expReads += (marker(s, b, 0) != 8'hFF) ? 1 : 2;
      if (expBad(s, b)) expCount++;
    end
    // R2, R5: read order and count
    chk(orderErr == 0 && colErr == 0, "R2 order/column errors", orderErr + colErr, 0);
    chk(readCnt == expReads, "R5 read count", readCnt, expReads);
    // R7, R8
    chk(int'(badCount) == expCount, "R7 bad count", int'(badCount), expCount);
    chk(tooManyBad == (expCount > 5), "R8 error flag", int'(tooManyBad), int'(expCount > 5));
    // R3, R4, R6 map and R10 lookup sweep
    for (int b = 0; b < 256; b++) begin
      lkBlock = 8'(b);
      #1;
      if (badMap[b] != expBad(s, b)) mapErr++;
      if (!lkReady || lkUsable != !expBad(s, b)) lkErr++;
    end
    chk(mapErr == 0, "R4 R6 bad map mismatches", mapErr, 0);
    chk(lkErr == 0, "R10 lookup mismatches", lkErr, 0);
    chk(!badMap[0], "R3 block 0 usable", int'(badMap[0]), 0);
    repeat (5) @(negedge clk);
    // R9
    chk(scanDone && !rdReq, "R9 done holds, no request", int'(rdReq), 0);
  endtask

  initial begin
    lkBlock = 8'd0;
    runScan(0, 0);
    runScan(1, 2);
    runScan(2, 1);
    runScan(3, 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 160000) begin
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end
endmodule